// File: doc/BRIEF.md
# GPIO Output Data Port with Atomic Bit Operations

This block holds the output levels of a bank of general-purpose pins and samples the levels of the matching input pins. It is reached through a plain register port: a byte offset, a write word, a write strobe and a read word. Besides the ordinary output data register, it offers three write-only views of that register. Each one acts only on the bit positions where the written word carries a 1. One view drives those bits high, one drives them low and one inverts them. Software can therefore change a few pins without first reading the register, and no other agent's update to the other pins is lost.

A fifth offset returns the input pin levels after a two-flop synchronizer. Pin direction and pin multiplexing belong to a neighbouring block, so this one only presents output levels and samples inputs. The register port has no handshake. A write is taken at the rising clock edge on which the strobe is high. A read is combinational on the offset. One access is made per cycle, and the block never stalls the bus.

Top module: `gpio_data_port`

## Requirements
- R1: While reset (rst_n low) is applied and right after it is released, pin_out is all zeros.
- R2: A write at offset 0x00 replaces the whole output register with bus_wdata on that clock edge; reading offset 0x00 returns the present value of pin_out.
- R3: A write at offset 0x04 drives high every output bit n for which bus_wdata bit n is 1; all other bits keep their value.
- R4: A write at offset 0x08 drives low every output bit n for which bus_wdata bit n is 1; all other bits keep their value.
- R5: A write at offset 0x0C inverts every output bit n for which bus_wdata bit n is 1; all other bits keep their value.
- R6: Reading offset 0x10 returns the pin_in value present two rising edges earlier (bit n is pin n). A change on pin_in is not yet visible after one edge.
- R7: Reads at offsets 0x04, 0x08 and 0x0C return zero, whatever the output register holds.
- R8: A write at any offset other than 0x00, 0x04, 0x08 and 0x0C leaves pin_out unchanged. This includes the read-only offset 0x10. A read at any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write word |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_rdata | output | 32 | Read word for the current offset (combinational) |
| pin_out | output | 32 | Output level per pin, bit n for pin n |
| pin_in | input | 32 | Raw input level per pin, bit n for pin n |

## Verification
On every cycle, assertions check the effect of each write kind on the output register across the clock edge. They check that writes to the read-only or unmapped offsets leave the register unchanged, that the alias offsets read zero, and that each synchronizer stage holds what the previous stage held one cycle earlier. Only the bench's scenarios show the things a single-cycle property cannot see. These are the absolute two-edge latency from pin to read word, the reset value, and the outcome of long mixed sequences of set, clear and toggle against an independent model. They also include the full sweep of all 256 offsets for ignored writes and zero reads.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Register offsets; fixed because software depends on them.
  localparam int unsigned OFS_DATA = 'h00;
  localparam int unsigned OFS_SET  = 'h04;
  localparam int unsigned OFS_CLR  = 'h08;
  localparam int unsigned OFS_TOG  = 'h0C;
  localparam int unsigned OFS_PINS = 'h10;

  typedef enum logic [2:0] {
    ACC_DATA,
    ACC_SET,
    ACC_CLR,
    ACC_TOG,
    ACC_PINS,
    ACC_NONE
  } acc_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc
);
  always_comb begin
    if      (addr == ADDR_W'(OFS_DATA)) acc = ACC_DATA;
    else if (addr == ADDR_W'(OFS_SET))  acc = ACC_SET;
    else if (addr == ADDR_W'(OFS_CLR))  acc = ACC_CLR;
    else if (addr == ADDR_W'(OFS_TOG))  acc = ACC_TOG;
    else if (addr == ADDR_W'(OFS_PINS)) acc = ACC_PINS;
    else                                acc = ACC_NONE;
  end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  acc_e         acc,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (we) begin
      case (acc)
        ACC_DATA: nxt = wdata;
        ACC_SET:  nxt = q | wdata;
        ACC_CLR:  nxt = q & ~wdata;
        ACC_TOG:  nxt = q ^ wdata;
        default:  nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && acc == ACC_DATA) |=> (q == $past(wdata))); // R2
  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && acc == ACC_SET) |=> (((q & $past(wdata)) == $past(wdata)) &&
                                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))); // R3
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && acc == ACC_CLR) |=> (((q & $past(wdata)) == '0) &&
                                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))); // R4
  AST_TOG_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && acc == ACC_TOG) |=> ((q ^ $past(q)) == $past(wdata))); // R5
  AST_IGNORED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_PINS || acc == ACC_NONE || !we) |=> $stable(q)); // R8
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;
  logic warm;

  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) st[0] <= '0;
          else        st[0] <= d;
        end
        AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
          warm |-> (st[0] == $past(d))); // R6
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) st[k] <= '0;
          else        st[k] <= st[k-1];
        end
        AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
          warm |-> (st[k] == $past(st[k-1]))); // R6
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_wr,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NPINS-1:0]  pin_out,
  input  logic [NPINS-1:0]  pin_in
);
  acc_e             acc;
  logic [NPINS-1:0] pins_sync;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .acc  (acc)
  );

  gpio_out_reg #(.W(NPINS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_wr),
    .acc   (acc),
    .wdata (bus_wdata),
    .q     (pin_out)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  always_comb begin
    case (acc)
      ACC_DATA: bus_rdata = pin_out;
      ACC_PINS: bus_rdata = pins_sync;
      default:  bus_rdata = '0;
    endcase
  end

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_CLR) ||
     bus_addr == ADDR_W'(OFS_TOG)) |-> (bus_rdata == '0)); // R7
  AST_DATA_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_DATA)) |-> (bus_rdata == pin_out)); // R2
endmodule

// File: tb/tb_gpio_data_port.sv
module tb_gpio_data_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic [31:0] bus_rdata;
  logic [31:0] pin_out;
  logic [31:0] pin_in;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  gpio_data_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_in(pin_in)
  );

  function automatic logic [31:0] nx(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13;
    y ^= y >> 17;
    y ^= y << 5;
    return y;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] model, rnd, rd, oldp;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", pin_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", pin_out, 32'h0);
    model = '0;
    rnd = 32'h1234_5678;

    // R2: full replacement and readback
    for (int i = 0; i < 20; i++) begin
      rnd = nx(rnd);
      bus_write(8'h00, rnd); model = rnd;
      check("R2 data write", pin_out, model);
      bus_read(8'h00, rd);
      check("R2 data readback", rd, model);
    end

    // R3/R4/R5: walking one per bit
    bus_write(8'h00, 32'h0); model = 32'h0;
    for (int b = 0; b < 32; b++) begin
      bus_write(8'h04, 32'h1 << b); model |= 32'h1 << b;
      check("R3 set walk", pin_out, model);
    end
    for (int b = 0; b < 32; b += 2) begin
      bus_write(8'h08, 32'h1 << b); model &= ~(32'h1 << b);
      check("R4 clear walk", pin_out, model);
    end
    for (int b = 0; b < 32; b++) begin
      bus_write(8'h0C, 32'h1 << b); model ^= 32'h1 << b;
      check("R5 toggle walk", pin_out, model);
    end

    // R3/R4/R5 mixed random sequence
    for (int i = 0; i < 150; i++) begin
      rnd = nx(rnd);
      case (i % 3)
        0: begin bus_write(8'h04, rnd); model = model | rnd;  check("R3 set rnd", pin_out, model); end
        1: begin bus_write(8'h08, rnd); model = model & ~rnd; check("R4 clear rnd", pin_out, model); end
        default: begin bus_write(8'h0C, rnd); model = model ^ rnd; check("R5 toggle rnd", pin_out, model); end
      endcase
    end

    // R7: alias offsets read zero with nonzero output
    bus_write(8'h00, 32'hFFFF_FFFF); model = 32'hFFFF_FFFF;
    bus_read(8'h04, rd); check("R7 set reads zero", rd, 32'h0);
    bus_read(8'h08, rd); check("R7 clear reads zero", rd, 32'h0);
    bus_read(8'h0C, rd); check("R7 toggle reads zero", rd, 32'h0);

    // R8: sweep every offset that is not a write target
    for (int a = 0; a < 256; a++) begin
      if (a != 'h00 && a != 'h04 && a != 'h08 && a != 'h0C) begin
        rnd = nx(rnd);
        bus_write(a[7:0], rnd);
        check("R8 ignored write", pin_out, model);
        if (a != 'h10) begin
          bus_read(a[7:0], rd);
          check("R8 unmapped read zero", rd, 32'h0);
        end
      end
    end

    // R6: two-edge input latency
    oldp = 32'h0;
    pin_in = oldp;
    bus_addr = 8'h10;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      rnd = nx(rnd);
      pin_in = rnd;
      @(negedge clk); #1;
      check("R6 not yet after one edge", bus_rdata, oldp);
      @(negedge clk); #1;
      check("R6 visible after two edges", bus_rdata, rnd);
      oldp = rnd;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule